// File: doc/BRIEF.md
# Runtime-Precision Fixed-Point Unit

This unit sits inside each processing cell of a neighbour-connected grid. It performs the three fixed-point operations of the cell's instruction set: a fixed-point product, a conversion from integer to fixed point, and a conversion from fixed point back to integer. The datapath is combinational. The only state is a small precision register that software writes while the program runs. That register sets how many of the W bits hold the fraction.

The binary point is not fixed when the hardware is built. The same hardware can run a wave solver in Q16.16 or a heat solver in Q8.8 on a 16-bit build, and a program can change format between phases. A precision of zero turns all three operations into plain integer operations. The unit does not saturate or round: results are truncated to W bits, and right shifts round toward negative infinity.

Top module: `fxu_top`

## Requirements
- R1: A synchronous active-high `rst` clears the precision register to 0. From the first cycle after reset, `op_sel`=1 returns `opnd_a` unchanged.
- R2: When `prec_we` is high at a rising clock edge, `prec_wdata` becomes the precision used from that edge on. While `prec_we` is low, the precision holds its value, and a pending write does not affect the result before its edge.
- R3: With `op_sel`=0 (fixed-point product, instruction opcode 11), `result` is the low W bits of the full 2W-bit signed product of `opnd_a` and `opnd_b`, arithmetically shifted right by the precision.
- R4: With `op_sel`=1 (integer to fixed, extension function 0), `result` is `opnd_a` shifted left by the precision and truncated to W bits.
- R5: With `op_sel`=2 (fixed to integer, extension function 1), `result` is `opnd_a` arithmetically shifted right by the precision. Fraction bits are dropped and negative values round toward negative infinity.
- R6: At precision 0, `op_sel`=0 gives the low W bits of the integer product, and `op_sel`=1 and `op_sel`=2 pass `opnd_a` through.
- R7: `op_sel`=3 is reserved and gives `result` = 0.
- R8: For `op_sel`=1 and `op_sel`=2, `opnd_b` has no effect on `result`.
- R9: `result` follows the operands and `op_sel` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the precision register |
| rst | input | 1 | Synchronous active-high reset |
| prec_we | input | 1 | Write strobe for the precision register |
| prec_wdata | input | $clog2(W) | New count of fraction bits |
| op_sel | input | 2 | 0 product, 1 to-fixed, 2 to-integer, 3 reserved |
| opnd_a | input | W | First operand, signed |
| opnd_b | input | W | Second operand, signed (used by the product only) |
| result | output | W | Operation result |

## Verification
The hardest case to reach from the ports is a write to precision that is pending but has not yet reached its clock edge. The old precision must still govern the result, and the new one must take over exactly one edge later. The bench holds the write strobe high and samples a conversion before the edge, then samples it again after the edge. Products whose 2W-bit intermediate overflows W bits, or whose value falls below zero, are also hard to reach. The bench gets there with operand vectors at the extreme precisions 0 and W-1.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

    typedef enum logic [1:0] {
        OP_FMUL  = 2'd0,
        OP_TOFIX = 2'd1,
        OP_TOINT = 2'd2,
        OP_RSV   = 2'd3
    } fx_op_e;

    typedef struct packed {
        logic fmul;
        logic tofix;
        logic toint;
    } fx_sel_t;

    function automatic fx_sel_t fx_decode(input fx_op_e op);
        fx_sel_t s;
        s.fmul  = (op == OP_FMUL);
        s.tofix = (op == OP_TOFIX);
        s.toint = (op == OP_TOINT);
        return s;
    endfunction

endpackage

// File: rtl/fxu_prec_reg.sv
module fxu_prec_reg #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] prec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prec <= '0;
        end else if (we) begin
            prec <= wdata;
        end
    end
endmodule

// File: rtl/fxu_mul.sv
module fxu_mul #(
    parameter int W  = 32,
    parameter int PW = 5
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic        [PW-1:0] prec,
    output logic        [W-1:0] prod_fx
);
    logic signed [2*W-1:0] prod_full;
    logic signed [2*W-1:0] prod_sh;

    always_comb begin
        prod_full = a * b;
        prod_sh   = prod_full >>> prec;
        prod_fx   = prod_sh[W-1:0];
    end
endmodule

// File: rtl/fxu_conv.sv
module fxu_conv #(
    parameter int W  = 32,
    parameter int PW = 5
) (
    input  logic signed [W-1:0] a,
    input  logic        [PW-1:0] prec,
    output logic        [W-1:0] to_fix,
    output logic        [W-1:0] to_int
);
    always_comb begin
        to_fix = a << prec;
        to_int = a >>> prec;
    end
endmodule

// File: rtl/fxu_top.sv
module fxu_top
    import fxu_pkg::*;
#(
    parameter int W  = 32,
    parameter int PW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prec_we,
    input  logic [PW-1:0] prec_wdata,
    input  logic [1:0]    op_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    output logic [W-1:0]  result
);
    logic [PW-1:0] prec;
    logic [W-1:0]  mul_res;
    logic [W-1:0]  fix_res;
    logic [W-1:0]  int_res;
    fx_sel_t       sel;

    fxu_prec_reg #(.PW(PW)) u_prec (
        .clk   (clk),
        .rst   (rst),
        .we    (prec_we),
        .wdata (prec_wdata),
        .prec  (prec)
    );

    fxu_mul #(.W(W), .PW(PW)) u_mul (
        .a       (opnd_a),
        .b       (opnd_b),
        .prec    (prec),
        .prod_fx (mul_res)
    );

    fxu_conv #(.W(W), .PW(PW)) u_conv (
        .a      (opnd_a),
        .prec   (prec),
        .to_fix (fix_res),
        .to_int (int_res)
    );

    always_comb begin
        sel = fx_decode(fx_op_e'(op_sel));
        unique case (1'b1)
            sel.fmul:  result = mul_res;
            sel.tofix: result = fix_res;
            sel.toint: result = int_res;
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/fxu_chk.sv
module fxu_chk #(
    parameter int W  = 32,
    parameter int PW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic          prec_we,
    input logic [PW-1:0] prec_wdata,
    input logic [1:0]    op_sel,
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [W-1:0]  result
);
    logic [PW-1:0] cp;
    logic signed [2*W-1:0] mprod;

    always_ff @(posedge clk) begin
        if (rst) cp <= '0;
        else if (prec_we) cp <= prec_wdata;
    end

    assign mprod = ($signed(opnd_a) * $signed(opnd_b)) >>> cp;

    p_prec_reset_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && op_sel == 2'd1) |-> result == opnd_a);

    p_fmul_r3: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'd0 |-> result == mprod[W-1:0]);

    p_tofix_r4: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'd1 |-> result == (opnd_a << cp));

    p_toint_r5: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'd2 |-> result == W'($signed(opnd_a) >>> cp));

    p_rsv_zero_r7: assert property (@(posedge clk) disable iff (rst)
        op_sel == 2'd3 |-> result == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(prec_we) && !$past(rst) && op_sel == 2'd2 && $stable(op_sel) && $stable(opnd_a))
        |-> $stable(result));
endmodule

bind fxu_top fxu_chk #(.W(W), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .prec_we    (prec_we),
    .prec_wdata (prec_wdata),
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result)
);

// File: tb/tb_fxu_top.sv
module tb_fxu_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int PW = $clog2(W);
    localparam int NV = 13;

    // {prec[7:0], op[1:0], a[31:0], b[31:0], expected[31:0]}
    localparam logic [105:0] VEC [NV] = '{
        {8'd16, 2'd0, 32'h0001_8000, 32'h0002_0000, 32'h0003_0000},
        {8'd16, 2'd0, 32'hFFFF_8000, 32'h0004_0000, 32'hFFFE_0000},
        {8'd16, 2'd1, 32'h0000_0005, 32'hDEAD_BEEF, 32'h0005_0000},
        {8'd16, 2'd2, 32'h0005_8000, 32'h0000_0000, 32'h0000_0005},
        {8'd16, 2'd2, 32'hFFFF_8000, 32'h1234_0000, 32'hFFFF_FFFF},
        {8'd0,  2'd0, 32'h0000_0007, 32'hFFFF_FFFD, 32'hFFFF_FFEB},
        {8'd0,  2'd1, 32'h1234_5678, 32'h0000_0001, 32'h1234_5678},
        {8'd0,  2'd2, 32'h8000_0001, 32'h0000_0009, 32'h8000_0001},
        {8'd8,  2'd0, 32'h0000_0180, 32'h0000_0180, 32'h0000_0240},
        {8'd4,  2'd1, 32'h1000_0001, 32'h0000_0000, 32'h0000_0010},
        {8'd31, 2'd0, 32'h4000_0000, 32'h4000_0000, 32'h2000_0000},
        {8'd16, 2'd0, 32'h7FFF_0000, 32'h0002_0000, 32'hFFFE_0000},
        {8'd3,  2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prec_we = 1'b0;
    logic [PW-1:0] prec_wdata = '0;
    logic [1:0]    op_sel = 2'd0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic [W-1:0]  result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fxu_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .prec_we(prec_we), .prec_wdata(prec_wdata),
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_prec(input int p);
        @(negedge clk);
        prec_we = 1'b1;
        prec_wdata = PW'(p);
        @(negedge clk);
        prec_we = 1'b0;
    endtask

    task automatic apply(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: precision is 0 after reset, conversion passes operand through
        apply(2'd1, 32'h0000_0005, 32'h0);
        check("R1 reset precision", result, 32'h0000_0005);

        // Vector table covering R3, R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            set_prec(int'(VEC[i][105:98]));
            apply(VEC[i][97:96], VEC[i][95:64], VEC[i][63:32]);
            check($sformatf("R3/R4/R5/R6/R7 vector %0d", i), result, VEC[i][31:0]);
        end

        // R2: pending write does not act before its edge
        set_prec(16);
        @(negedge clk);
        apply(2'd1, 32'h0000_0001, 32'h0);
        prec_we = 1'b1;
        prec_wdata = PW'(4);
        #1;
        check("R2 before edge", result, 32'h0001_0000);
        @(negedge clk);
        prec_we = 1'b0;
        #1;
        check("R2 after edge", result, 32'h0000_0010);
        prec_wdata = PW'(9);
        @(negedge clk);
        #1;
        check("R2 hold with strobe low", result, 32'h0000_0010);

        // R8: opnd_b ignored by conversions
        apply(2'd1, 32'h0000_0003, 32'h0000_0000);
        check("R8 to-fix b=0", result, 32'h0000_0030);
        apply(2'd1, 32'h0000_0003, 32'hFFFF_FFFF);
        check("R8 to-fix b=all ones", result, 32'h0000_0030);
        apply(2'd2, 32'hFFFF_FF00, 32'h7FFF_FFFF);
        check("R8 to-int b ignored", result, 32'hFFFF_FFF0);

        // R9: same-cycle response to operand change without a clock edge
        apply(2'd0, 32'h0000_0020, 32'h0000_0030);
        check("R9 combinational product", result, 32'h0000_0060);

        // R1: mid-run reset returns precision to 0
        set_prec(8);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        apply(2'd2, 32'h0000_1234, 32'h0);
        check("R1 reset clears precision", result, 32'h0000_1234);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule